// File: doc/BRIEF.md
# Receive Deserializer with Loss-of-Signal Mute

This block turns a recovered serial bit stream into parallel words. It runs on the recovered bit clock and counts fixed word boundaries from reset. It also produces a parallel clock at one word-width fraction of the bit rate, which downstream logic uses to sample the words. The first bit of each group goes to the most significant bit of the word. A new word appears at the same bit-clock edge on which the parallel clock falls.

The block can mute the words. Two sources declare loss of signal: a flag from an on-chip detector and a pin from the optical module. While either is active, each completed word is replaced by all zeros, so line noise is not passed on as data. A status output shows that the mute is applied. A detect-disable input turns off both sources. While any local loopback path is enabled, the mute is never applied, so a loopback test sees its own data. With the default word width of 8, the same logic serves both line rates: 622.08 Mb/s with a 77.76 MHz parallel clock, and 155.52 Mb/s with a 19.44 MHz parallel clock.

Top module: `rx_deser_mute`

## Requirements
- R1: A synchronous active-high reset drives the word output, the parallel clock and the mute status to 0. The first bit sampled after reset is bit 7 of the first word, even when reset interrupts a partly received word.
- R2: Each word holds 8 consecutive serial bits. The earliest bit lands on bit 7 and the latest on bit 0.
- R3: The parallel clock has a period of 8 bit clocks. It is low for the 4 bit clocks after a word boundary and high for the next 4. It is high from the 4th bit-clock edge after reset.
- R4: The word output and the mute status change only at the bit-clock edge where the parallel clock falls. They hold their values during the other 7 bit clocks.
- R5: When the mute condition holds at a word's last bit, that word is output as all zeros and the mute status is 1. Otherwise the word is output unchanged and the mute status is 0.
- R6: Loss of signal is declared when the internal detector flag is 1, or when the external loss-of-signal input is 1, or both.
- R7: While the detect-disable input is 1, neither loss-of-signal source mutes the data.
- R8: While any bit of the loopback-enable vector is 1, the mute is not applied, whatever the loss-of-signal inputs are.
- R9: The first word whose last bit is sampled after loss of signal clears is passed unmuted, and the mute status returns to 0.
- R10: Word k (counting from 0 after reset) appears on the output after bit-clock edge 8(k+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit_i | input | 1 | Recovered serial bit clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ser_i | input | 1 | Serial data, sampled on the rising bit-clock edge |
| los_int_i | input | 1 | Loss-of-signal flag from the internal detector |
| los_ext_i | input | 1 | Loss-of-signal input from the optical module |
| los_det_dis_i | input | 1 | Disables loss-of-signal muting when 1 |
| lpbk_en_i | input | LPBK_N | Local loopback enables; bit 0 is digital, bit 1 is analog |
| par_data_o | output | WORD_W | Parallel word |
| par_clk_o | output | 1 | Parallel clock, bit clock divided by WORD_W |
| los_mute_o | output | 1 | 1 while the current word is muted |

## Verification
Two cases are hard to reach from the ports.

The first is a reset that arrives in the middle of a word. Its effect shows only in the alignment of the words that follow. The bench sends three stray bits, applies reset, and then checks that the next known bytes come out whole, with the parallel-clock phase counted again from reset.

The second is the precedence between the mute sources and the two overrides. Every loss-of-signal combination is driven for a whole word against the disable input and against each loopback bit. The mute-to-clean transition is then checked on the word that follows.

// File: rtl/rxdes_pkg.sv
package rxdes_pkg;

   // Mute controls, gathered together for the mute decision logic.
   typedef struct packed {
      logic los_int;
      logic los_ext;
      logic det_dis;
      logic lpbk_any;
   } los_ctl_t;

   // Width of a counter that counts 0 .. n-1 (at least 1 bit).
   function automatic int cnt_width(input int n);
      return (n > 2) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/rxdes_bitcnt.sv
module rxdes_bitcnt #(
   parameter int WORD_W = 8
) (
   input  logic clk_i,
   input  logic rst_i,
   output logic word_last_o,
   output logic par_clk_o
);
   import rxdes_pkg::*;

   localparam int CW   = cnt_width(WORD_W);
   localparam int HALF = WORD_W / 2;

   generate
      if (WORD_W < 2 || (WORD_W % 2) != 0) begin : g_bad_width
         $error("rxdes_bitcnt: WORD_W must be even and at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign word_last_o = (cnt == CW'(WORD_W - 1));

   always_ff @(posedge clk_i) begin
      if (rst_i)            cnt <= '0;
      else if (word_last_o) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

   // Parallel clock: low for the first half of the word, high for the second.
   always_ff @(posedge clk_i) begin
      if (rst_i)                        par_clk_o <= 1'b0;
      else if (cnt == CW'(HALF - 1))    par_clk_o <= 1'b1;
      else if (word_last_o)             par_clk_o <= 1'b0;
   end

   AST_PCLK_RISE_MID: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(par_clk_o) |-> (cnt == CW'(HALF)));   // R3

endmodule

// File: rtl/rxdes_shift.sv
module rxdes_shift #(
   parameter int WORD_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              ser_i,
   output logic [WORD_W-1:0] word_o
);
   logic [WORD_W-1:0] sh_q;
   logic [WORD_W-1:0] sh_d;

   generate
      if (MSB_FIRST) begin : g_msb
         // The earliest bit moves up towards the MSB.
         assign sh_d = {sh_q[WORD_W-2:0], ser_i};
      end else begin : g_lsb
         assign sh_d = {ser_i, sh_q[WORD_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) sh_q <= '0;
      else       sh_q <= sh_d;
   end

   // The complete word, including the bit sampled at this edge.
   assign word_o = sh_d;

endmodule

// File: rtl/rxdes_mute.sv
module rxdes_mute #(
   parameter int LPBK_N = 2
) (
   input  logic              los_int_i,
   input  logic              los_ext_i,
   input  logic              det_dis_i,
   input  logic [LPBK_N-1:0] lpbk_en_i,
   output logic              mute_o
);
   import rxdes_pkg::*;

   generate
      if (LPBK_N < 1) begin : g_bad_lpbk
         $error("rxdes_mute: LPBK_N must be at least 1");
      end
   endgenerate

   los_ctl_t ctl;

   always_comb begin
      ctl.los_int  = los_int_i;
      ctl.los_ext  = los_ext_i;
      ctl.det_dis  = det_dis_i;
      ctl.lpbk_any = |lpbk_en_i;
      mute_o = (ctl.los_int | ctl.los_ext) & ~ctl.det_dis & ~ctl.lpbk_any;
   end

endmodule

// File: rtl/rx_deser_mute.sv
module rx_deser_mute #(
   parameter int WORD_W    = 8,
   parameter int LPBK_N    = 2,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk_bit_i,
   input  logic              rst_i,
   input  logic              ser_i,
   input  logic              los_int_i,
   input  logic              los_ext_i,
   input  logic              los_det_dis_i,
   input  logic [LPBK_N-1:0] lpbk_en_i,
   output logic [WORD_W-1:0] par_data_o,
   output logic              par_clk_o,
   output logic              los_mute_o
);
   logic              word_last;
   logic [WORD_W-1:0] word;
   logic              mute_req;

   rxdes_bitcnt #(.WORD_W(WORD_W)) u_cnt (
      .clk_i       (clk_bit_i),
      .rst_i       (rst_i),
      .word_last_o (word_last),
      .par_clk_o   (par_clk_o)
   );

   rxdes_shift #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk_i  (clk_bit_i),
      .rst_i  (rst_i),
      .ser_i  (ser_i),
      .word_o (word)
   );

   rxdes_mute #(.LPBK_N(LPBK_N)) u_mute (
      .los_int_i (los_int_i),
      .los_ext_i (los_ext_i),
      .det_dis_i (los_det_dis_i),
      .lpbk_en_i (lpbk_en_i),
      .mute_o    (mute_req)
   );

   // Output word register, loaded at the word boundary (parallel clock fall).
   always_ff @(posedge clk_bit_i) begin
      if (rst_i) begin
         par_data_o <= '0;
         los_mute_o <= 1'b0;
      end else if (word_last) begin
         par_data_o <= mute_req ? '0 : word;
         los_mute_o <= mute_req;
      end
   end

   AST_DATA_AT_FALL: assert property (@(posedge clk_bit_i) disable iff (rst_i)
      !$stable(par_data_o) |-> $fell(par_clk_o));   // R4

   AST_MUTE_ZERO: assert property (@(posedge clk_bit_i) disable iff (rst_i)
      los_mute_o |-> (par_data_o == '0));   // R5

   AST_DIS_BLOCKS: assert property (@(posedge clk_bit_i) disable iff (rst_i)
      $rose(los_mute_o) |-> !$past(los_det_dis_i));   // R7

   AST_LPBK_BLOCKS: assert property (@(posedge clk_bit_i) disable iff (rst_i)
      $rose(los_mute_o) |-> ($past(lpbk_en_i) == '0));   // R8

endmodule

// File: tb/rx_deser_mute_tb.sv
module rx_deser_mute_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ser = 1'b0;
   logic       li = 1'b0, le = 1'b0, ds = 1'b0;
   logic [1:0] lp = 2'b00;
   logic [7:0] dout;
   logic       pclk, mute;

   int n_chk = 0, n_bad = 0, ecnt = 0;
   logic [7:0] prev_d = 8'h00;
   logic       prev_m = 1'b0;

   always #10 clk = ~clk;

   rx_deser_mute u_dut (
      .clk_bit_i(clk), .rst_i(rst), .ser_i(ser),
      .los_int_i(li), .los_ext_i(le), .los_det_dis_i(ds),
      .lpbk_en_i(lp), .par_data_o(dout), .par_clk_o(pclk), .los_mute_o(mute)
   );

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1; ser = 1'b0;
      @(posedge clk); @(posedge clk); #1;
      chk(dout == 8'h00, "R1 data", dout, 0);
      chk(pclk == 1'b0, "R1 pclk", pclk, 0);
      chk(mute == 1'b0, "R1 mute", mute, 0);
      ecnt = 0; prev_d = 8'h00; prev_m = 1'b0;
   endtask

   task automatic send_bits(input logic [7:0] d, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); rst = 1'b0; ser = d[7-i];
         @(posedge clk); #1; ecnt++;
      end
   endtask

   task automatic send_word(input logic [7:0] d, input logic i_int, input logic i_ext,
                            input logic i_dis, input logic [1:0] i_lp, input string rq);
      logic       m;
      logic [7:0] ed;
      m  = !i_dis && (i_lp == 2'b00) && (i_int || i_ext);
      ed = m ? 8'h00 : d;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         rst = 1'b0; ser = d[7-i];
         li = i_int; le = i_ext; ds = i_dis; lp = i_lp;
         @(posedge clk); #1; ecnt++;
         chk(pclk == ((ecnt % 8) >= 4), "R3 pclk phase", pclk, ((ecnt % 8) >= 4));
         if (i < 7) begin
            chk(dout == prev_d && mute == prev_m, "R4 hold mid-word", dout, prev_d);
         end
      end
      chk(dout == ed, rq, dout, ed);
      chk(mute == m, {rq, " status"}, mute, m);
      prev_d = ed; prev_m = m;
   endtask

   task automatic t_basic();
      send_word(8'hA5, 0, 0, 0, 2'b00, "R2 R10 word0");
      send_word(8'h3C, 0, 0, 0, 2'b00, "R2 R10 word1");
      send_word(8'hFF, 0, 0, 0, 2'b00, "R2 ones");
      send_word(8'h00, 0, 0, 0, 2'b00, "R2 zeros");
      send_word(8'h81, 0, 0, 0, 2'b00, "R2 msb first");
   endtask

   task automatic t_los_sources();
      send_word(8'h5A, 1, 0, 0, 2'b00, "R5 R6 internal los");
      send_word(8'hC3, 0, 1, 0, 2'b00, "R5 R6 external los");
      send_word(8'h7E, 1, 1, 0, 2'b00, "R6 both los");
   endtask

   task automatic t_release();
      send_word(8'h99, 1, 0, 0, 2'b00, "R5 muted before release");
      send_word(8'h66, 0, 0, 0, 2'b00, "R9 first clean word");
   endtask

   task automatic t_disable();
      send_word(8'h12, 1, 0, 1, 2'b00, "R7 dis internal");
      send_word(8'h34, 0, 1, 1, 2'b00, "R7 dis external");
      send_word(8'h56, 1, 1, 1, 2'b00, "R7 dis both");
   endtask

   task automatic t_loopback();
      send_word(8'hE1, 1, 1, 0, 2'b01, "R8 digital loopback");
      send_word(8'hD2, 1, 0, 0, 2'b10, "R8 analog loopback");
      send_word(8'hB4, 0, 1, 0, 2'b11, "R8 both loopbacks");
      send_word(8'h78, 1, 1, 0, 2'b00, "R5 mute after loopback off");
   endtask

   task automatic t_mid_reset();
      send_bits(8'hE0, 3);
      do_reset();
      send_word(8'hC5, 0, 0, 0, 2'b00, "R1 realign word0");
      send_word(8'h3A, 0, 0, 0, 2'b00, "R1 realign word1");
   endtask

   initial begin
      #(20 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      do_reset();
      t_basic();
      t_los_sources();
      t_release();
      t_disable();
      t_loopback();
      t_mid_reset();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule